// File: doc/BRIEF.md
# Flash Page Refresh Sequencer with Ready Polling

This block is the host-side SPI master that refreshes one page of a serial flash device on request. A requester pulses a start input along with a buffer select and a 12-bit page number. The block then shifts out a four-byte command frame: a rewrite opcode that names the staging buffer, followed by a 24-bit address field that carries the page number. Next it raises chip select, because that rising edge is what starts the device's internal rewrite.

After a minimum chip-select high gap, the block opens a status-read frame. It sends the status opcode and then keeps clocking with chip select held low. The device repeats its status byte for as long as the frame stays open. The block checks the ready flag in each received byte and does not resend the opcode. It closes the frame on the first byte that reports ready, or when a parameterised count of status bytes has been used up. After a closing gap it pulses either done or timeout. The busy output stays high through the whole sequence, and any start request that arrives during that time is dropped.

The SCK rate is set by a system-clock divider parameter, and the polling limit is set by its own parameter.

Top module: `page_rewrite_poller`

## Requirements
- R1: After reset, and while reset is held, spi_cs_no is 1, spi_sck_o is 0, and busy_o, done_o and timeout_o are 0. A reset in the middle of a sequence returns the block to this idle state.
- R2: The command frame is exactly 32 SCK cycles long, sent most significant bit first. Its first byte is 0x58 when buf_sel_i is 0 and 0x59 when buf_sel_i is 1.
- R3: The 24 address bits that follow the opcode are 3 zero bits, then page_i[11:0] from bit 11 down to bit 0, then 9 zero bits. Bits 23..0 of the frame are therefore {3'b000, page, 9'b0}.
- R4: SPI mode 0 is used. SCK is low whenever CS is high and idles low. MOSI does not change while SCK is high. MISO is sampled on the rising SCK edge.
- R5: spi_cs_no goes high after the 32nd command bit. It stays high for at least 2*CLK_DIV system clocks before it falls again for the status frame.
- R6: The status frame starts with opcode 0x57. MISO during that opcode byte is ignored. Every following byte is clocked with CS held low, and only its bit 7 is examined. The first byte with bit 7 equal to 1 closes the frame, and done_o then pulses for one cycle.
- R7: If POLL_MAX consecutive status bytes all have bit 7 equal to 0, the frame closes after exactly POLL_MAX status bytes. timeout_o then pulses for one cycle and done_o stays low. A ready flag in byte POLL_MAX still counts as done.
- R8: busy_o is high from the cycle after a start is accepted until the cycle in which done_o or timeout_o pulses. A start_i that arrives while busy_o is high is ignored: it produces no extra frame and does not change the page or buffer in use.
- R9: done_o and timeout_o never pulse together. Either pulse comes only after CS has been high again for at least 2*CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; accepted only while idle |
| buf_sel_i | input | 1 | Staging buffer: 0 selects opcode 0x58, 1 selects opcode 0x59 |
| page_i | input | 12 | Page number to refresh |
| busy_o | output | 1 | Sequence in progress; start requests are dropped |
| done_o | output | 1 | One-cycle pulse: device reported ready |
| timeout_o | output | 1 | One-cycle pulse: polling limit reached without ready |
| spi_sck_o | output | 1 | SPI clock, mode 0 |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to the device |
| spi_miso_i | input | 1 | SPI data from the device |

## Verification
The bench's device model drives all ones on MISO during the status opcode byte. A design that checked the ready bit too early would therefore finish after zero polls, and the status-frame length check would catch it. Busy status bytes carry 0x7F, so a design that tested any bit other than bit 7 would also stop early. The vectors put the ready byte exactly at position POLL_MAX and also one position past it, to catch an off-by-one in the poll limit, which would show up as a wrong done/timeout outcome or a wrong frame length. Further directed cases cover the following: a start pulse while busy, which must not restart the sequence or change the page sent; a reset in the middle of the command frame, which must idle the SPI pins at once; and the chip-select gap, which a design that reopened the frame too quickly would violate.

// File: rtl/prw_pkg.sv
package prw_pkg;

  localparam int PAGE_W = 12;

  localparam logic [7:0] OP_REWRITE_BASE = 8'h58;
  localparam logic [7:0] OP_STATUS       = 8'h57;
  localparam logic [7:0] OP_FILL         = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_SOP,
    ST_POLL,
    ST_TAIL
  } seq_state_e;

  // byte idx of the 4-byte rewrite frame; address = {3'b0, page, 9'b0}
  function automatic logic [7:0] cmd_byte(input logic [1:0] idx,
                                          input logic sel,
                                          input logic [PAGE_W-1:0] page);
    logic [23:0] addr;
    addr = {3'b000, page, 9'b0};
    case (idx)
      2'd0:    cmd_byte = OP_REWRITE_BASE | {7'b0, sel};
      2'd1:    cmd_byte = addr[23:16];
      2'd2:    cmd_byte = addr[15:8];
      default: cmd_byte = addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/prw_byte_shifter.sv
module prw_byte_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;
  logic             sck_q;
  logic             done_q;
  logic [7:0]       rx_out_q;
  logic             tick;

  assign tick = active_q && (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      rx_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (load_i) begin
          active_q <= 1'b1;
          div_q    <= '0;
          bit_q    <= '0;
          tx_q     <= tx_byte_i;
          sck_q    <= 1'b0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
              rx_out_q <= rx_q;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign sck_o     = sck_q;
  assign mosi_o    = tx_q[7];
  assign done_o    = done_q;
  assign rx_byte_o = rx_out_q;

endmodule

// File: rtl/prw_gap_timer.sv
module prw_gap_timer #(
  parameter int GAP_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic fire_o
);

  localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (start_i) begin
        cnt_q <= CNT_W'(GAP_CYC - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/prw_seq_ctrl.sv
module prw_seq_ctrl
  import prw_pkg::*;
#(
  parameter int POLL_MAX = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              buf_sel_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              byte_done_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              gap_fire_i,
  output logic              load_o,
  output logic [7:0]        tx_byte_o,
  output logic              gap_start_o,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  seq_state_e        state_q;
  logic [1:0]        idx_q;
  logic [POLL_W-1:0] poll_q;
  logic              sel_q;
  logic [PAGE_W-1:0] page_q;
  logic              cs_n_q;
  logic              load_q;
  logic [7:0]        tx_q;
  logic              gap_go_q;
  logic              hit_q;
  logic              done_q;
  logic              tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      poll_q   <= '0;
      sel_q    <= 1'b0;
      page_q   <= '0;
      cs_n_q   <= 1'b1;
      load_q   <= 1'b0;
      tx_q     <= '0;
      gap_go_q <= 1'b0;
      hit_q    <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      load_q   <= 1'b0;
      gap_go_q <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sel_q   <= buf_sel_i;
            page_q  <= page_i;
            cs_n_q  <= 1'b0;
            tx_q    <= cmd_byte(2'd0, buf_sel_i, page_i);
            load_q  <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (byte_done_i) begin
            if (idx_q == 2'd3) begin
              cs_n_q   <= 1'b1;  // rising CS launches the rewrite
              gap_go_q <= 1'b1;
              state_q  <= ST_GAP;
            end else begin
              idx_q  <= idx_q + 2'd1;
              tx_q   <= cmd_byte(idx_q + 2'd1, sel_q, page_q);
              load_q <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gap_fire_i) begin
            cs_n_q  <= 1'b0;
            tx_q    <= OP_STATUS;
            load_q  <= 1'b1;
            state_q <= ST_SOP;
          end
        end
        ST_SOP: begin
          if (byte_done_i) begin
            tx_q    <= OP_FILL;
            load_q  <= 1'b1;
            poll_q  <= '0;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (byte_done_i) begin
            if (rx_byte_i[7] || poll_q == POLL_LAST) begin
              hit_q    <= rx_byte_i[7];
              cs_n_q   <= 1'b1;
              gap_go_q <= 1'b1;
              state_q  <= ST_TAIL;
            end else begin
              poll_q <= poll_q + 1'b1;
              load_q <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (gap_fire_i) begin
            done_q  <= hit_q;
            tmo_q   <= !hit_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o      = load_q;
  assign tx_byte_o   = tx_q;
  assign gap_start_o = gap_go_q;
  assign cs_n_o      = cs_n_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;

endmodule

// File: rtl/page_rewrite_poller.sv
module page_rewrite_poller
  import prw_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int POLL_MAX = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              buf_sel_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);

  localparam int GAP_CYC = 2 * CLK_DIV;

  logic       load;
  logic [7:0] tx_byte;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       gap_start;
  logic       gap_fire;

  prw_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tx_byte_i (tx_byte),
    .miso_i    (spi_miso_i),
    .sck_o     (spi_sck_o),
    .mosi_o    (spi_mosi_o),
    .done_o    (byte_done),
    .rx_byte_o (rx_byte)
  );

  prw_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (gap_start),
    .fire_o  (gap_fire)
  );

  prw_seq_ctrl #(.POLL_MAX(POLL_MAX)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .buf_sel_i   (buf_sel_i),
    .page_i      (page_i),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .gap_fire_i  (gap_fire),
    .load_o      (load),
    .tx_byte_o   (tx_byte),
    .gap_start_o (gap_start),
    .cs_n_o      (spi_cs_no),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

endmodule

// File: rtl/prw_checker.sv
module prw_checker #(
  parameter int CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic spi_sck_o,
  input logic spi_cs_no,
  input logic spi_mosi_o
);

  localparam int GAP_CYC = 2 * CLK_DIV;

  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt_q <= '0;
    else if (!spi_cs_no) hi_cnt_q <= '0;
    else if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 16'd1;
  end

  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> spi_cs_no); // R1

  AST_SCK_LOW_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R4

  AST_MOSI_HOLD_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> $stable(spi_mosi_o)); // R4

  AST_CS_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(spi_cs_no) && $past(busy_o)) |-> (hi_cnt_q >= 16'(GAP_CYC))); // R5

  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o)); // R9

  AST_RESULT_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> (spi_cs_no && hi_cnt_q >= 16'(GAP_CYC))); // R9

  AST_RESULT_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> ($past(busy_o) && !busy_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R7

  AST_START_TAKES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R8

endmodule

bind page_rewrite_poller prw_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .spi_sck_o  (spi_sck_o),
  .spi_cs_no  (spi_cs_no),
  .spi_mosi_o (spi_mosi_o)
);

// File: tb/page_rewrite_poller_tb.sv
module page_rewrite_poller_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int POLL_MAX   = 8;
  localparam int GAP_CYC    = 2 * CLK_DIV;
  localparam int N_VEC      = 6;

  // {sel, page[11:0], busy_bytes[7:0], expect_timeout}
  localparam logic [21:0] VEC [N_VEC] = '{
    {1'b0, 12'h000, 8'd0,  1'b0},
    {1'b1, 12'hFFF, 8'd3,  1'b0},
    {1'b0, 12'hA5C, 8'd7,  1'b0},
    {1'b1, 12'h123, 8'd8,  1'b1},
    {1'b0, 12'h801, 8'd20, 1'b1},
    {1'b1, 12'h555, 8'd1,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        buf_sel = 1'b0;
  logic [11:0] page = '0;
  logic        busy, done, tmo, sck, cs_n, mosi;
  logic        miso;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  // device model state
  int          frame_no = 0;
  int          bitcnt = 0;
  int          busy_cfg = 0;
  int          f0_bits = 0;
  int          f1_bits = 0;
  int          gap_cnt = 0;
  int          mode_err = 0;
  logic [31:0] shreg = '0;
  logic [31:0] f0_word = '0;
  logic [7:0]  f1_op = '0;
  logic        prev_cs = 1'b1;
  logic        prev_sck = 1'b0;
  logic        prev_mosi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_rewrite_poller #(.CLK_DIV(CLK_DIV), .POLL_MAX(POLL_MAX)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .buf_sel_i  (buf_sel),
    .page_i     (page),
    .busy_o     (busy),
    .done_o     (done),
    .timeout_o  (tmo),
    .spi_sck_o  (sck),
    .spi_cs_no  (cs_n),
    .spi_mosi_o (mosi),
    .spi_miso_i (miso)
  );

  // MISO: ones during the status opcode, 0x7F while busy, 0xA0 once ready
  always_comb begin
    logic [7:0] sbyte;
    miso = 1'b1;
    if (frame_no == 2 && bitcnt >= 8) begin
      sbyte = (((bitcnt - 8) / 8) >= busy_cfg) ? 8'hA0 : 8'h7F;
      miso  = sbyte[7 - ((bitcnt - 8) % 8)];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (prev_cs && !cs_n) begin
      frame_no++;
      bitcnt = 0;
      shreg  = '0;
    end
    if (!prev_cs && cs_n) begin
      if (frame_no == 1) begin f0_bits = bitcnt; f0_word = shreg; end
      if (frame_no == 2) f1_bits = bitcnt;
    end
    if (cs_n && frame_no == 1) gap_cnt++;
    if (!cs_n && !prev_sck && sck) begin
      shreg = {shreg[30:0], mosi};
      bitcnt++;
      if (frame_no == 2 && bitcnt == 8) f1_op = shreg[7:0];
    end
    if (sck && prev_sck && mosi != prev_mosi) mode_err++;
    prev_cs   = cs_n;
    prev_sck  = sck;
    prev_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_clear(input int n_busy);
    frame_no = 0; bitcnt = 0; f0_bits = 0; f1_bits = 0; gap_cnt = 0;
    mode_err = 0; f0_word = '0; f1_op = '0; busy_cfg = n_busy;
  endtask

  task automatic run_op(input logic sel, input logic [11:0] pg, input int n_busy,
                        input bit exp_tmo, input bit inject);
    bit got_done, got_tmo;
    logic [31:0] exp_word;
    int exp_bits;
    got_done = 0; got_tmo = 0;
    @(negedge clk);
    model_clear(n_busy);
    start = 1'b1; buf_sel = sel; page = pg;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int i = 0; i < 20000; i++) begin
      if (inject && i == 40) begin
        start = 1'b1; buf_sel = ~sel; page = ~pg;
      end else begin
        start = 1'b0;
      end
      if (done || tmo) begin
        got_done = done; got_tmo = tmo;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!got_done && !got_tmo) chk(1'b0, "R8 sequence never finished", 0, 1);
    chk(busy == 1'b0, "R8 busy low with result", busy, 0);
    exp_word = {7'b0101100, sel, 3'b000, pg, 9'b0};
    chk(f0_bits == 32, "R2 command frame length", f0_bits, 32);
    chk(f0_word[31:24] == exp_word[31:24], "R2 rewrite opcode", f0_word[31:24], exp_word[31:24]);
    chk(f0_word[23:0] == exp_word[23:0], "R3 address field", f0_word[23:0], exp_word[23:0]);
    chk(gap_cnt >= GAP_CYC, "R5 CS gap before status", gap_cnt, GAP_CYC);
    chk(f1_op == 8'h57, "R6 status opcode", f1_op, 8'h57);
    chk(mode_err == 0, "R4 MOSI moved while SCK high", mode_err, 0);
    exp_bits = exp_tmo ? (8 + 8 * POLL_MAX) : (8 + 8 * (n_busy + 1));
    if (exp_tmo) begin
      chk(got_tmo && !got_done, "R7 timeout reported", {got_done, got_tmo}, 2'b01);
      chk(f1_bits == exp_bits, "R7 status frame length", f1_bits, exp_bits);
    end else begin
      chk(got_done && !got_tmo, "R6 done reported", {got_done, got_tmo}, 2'b10);
      chk(f1_bits == exp_bits, "R6 status frame length", f1_bits, exp_bits);
    end
    @(negedge clk);
    chk(!done && !tmo, "R9 result is one-cycle pulse", {done, tmo}, 0);
    chk(frame_no == 2 && cs_n, "R8 no extra frame", frame_no, 2);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy && !done && !tmo, "R1 reset state",
        {cs_n, sck, busy, done, tmo}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy, "R1 idle after reset release", {cs_n, busy}, 2'b10);

    for (int v = 0; v < N_VEC; v++) begin
      run_op(VEC[v][21], VEC[v][20:9], int'(VEC[v][8:1]), VEC[v][0], 1'b0);
    end

    // R8: start while busy must not restart or alter the page
    run_op(1'b0, 12'h3C3, 2, 1'b0, 1'b1);

    // R1: reset in the middle of the command frame
    @(negedge clk);
    model_clear(0);
    start = 1'b1; buf_sel = 1'b1; page = 12'h0F0;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && !sck && !busy && !done && !tmo, "R1 mid-sequence reset",
        {cs_n, sck, busy, done, tmo}, 5'b10000);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(cs_n && !busy && frame_no == 1, "R1 stays idle after reset", {cs_n, busy}, 2'b10);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000 && !finished) begin
        finished = 1;
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

endmodule